// File: doc/BRIEF.md
# Stack push/pop transfer sequencer

This block breaks one multiple-register stack transfer into a run of single-word memory accesses. The caller supplies a 16-bit register mask, the current stack pointer and a direction bit (push or pop), and then raises a start strobe. The sequencer first checks whether the mask is legal for the chosen direction. It then drives a word-wide memory port with one access per accepted handshake. It takes store data from a register-file read port and returns loaded words on a register-file write port. At the end it writes the final address back to the stack pointer.

The stack is full-descending. On a push the pointer is first lowered by one word for each listed register, and the stores then fill that region. On a pop the loads start at the current pointer and the pointer rises past the words read. The program counter is never written through the register-file port. A pop that loads it instead produces a branch target, or an execution fault when the loaded word is even.

Top module: `stk_xfer_seq`

## Requirements
- R1: A legal push of n registers writes register i to address sp-4n+4k, where k is the number of listed registers below i. The stores are issued in decreasing address order (highest-numbered register first), one word (4 bytes) apart.
- R2: A legal pop of n registers loads the word at sp+4k into register i, where k is the number of listed registers below i. The loads are issued in increasing address order (lowest-numbered register first).
- R3: Every legal command asserts sp_we_o for exactly one cycle. The value is sp-4n for a push and sp+4n for a pop.
- R4: An empty mask raises err_o and makes no memory access and no stack-pointer write.
- R5: A mask with bit 13 (stack pointer) set is illegal in both directions and behaves as in R4.
- R6: A push whose mask has bit 15 (program counter) set is illegal and behaves as in R4.
- R7: A pop whose mask has both bit 14 (link register) and bit 15 set is illegal and behaves as in R4. A pop with only one of these two bits set is legal.
- R8: A pop that loads register 15 with bit 0 set raises br_valid_o with br_target_o equal to the loaded word with bit 0 cleared. It does not write register 15 through the register-file port.
- R9: A pop that loads register 15 with bit 0 clear raises fault_o and does not raise br_valid_o.
- R10: While mem_req_o is high and mem_ready_i is low, mem_addr_o, mem_we_o and (for writes) mem_wdata_o hold their values into the next cycle.
- R11: done_o pulses for one cycle. For a legal command the pulse comes in the cycle after the stack-pointer write; err_o, br_valid_o and fault_o are valid only in that cycle. busy_o is high from the cycle after an accepted start until done_o, and a start received while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken only when idle |
| pop_i | input | 1 | 1 = pop, 0 = push |
| reg_mask_i | input | 16 | Register list, bit i selects register i |
| sp_i | input | 32 | Current stack pointer |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal mask, valid with done_o |
| fault_o | output | 1 | Even program-counter value loaded, valid with done_o |
| br_valid_o | output | 1 | Branch requested, valid with done_o |
| br_target_o | output | 32 | Halfword-aligned branch target |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_ready_i | input | 1 | Access accepted / load data valid |
| mem_rdata_i | input | 32 | Load data |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| sp_we_o | output | 1 | Stack-pointer writeback strobe |
| sp_wdata_o | output | 32 | New stack pointer |

## Verification
The bench targets transfer ordering in both directions with sparse and full masks. A picker that scanned the wrong way would place registers at mirrored addresses, and the bench catches that through the memory and register contents and the address sequence. Each illegal mask shape is tried, including the legal pops with only the link register or only the program counter. A checker that confused these cases would either touch memory on an illegal command or refuse a legal one. Wait states are inserted so that a design that advanced without ready would skip or repeat words. The bench also issues a second start in mid-transfer, which a design that did not ignore it would let corrupt the running command. Pops of odd and even program-counter values show whether bit 0 is cleared on the branch target and whether the fault flag is raised only for even values.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } stk_state_e;
endpackage

// File: rtl/stk_list_check.sv
module stk_list_check #(
  parameter int NREG   = 16,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int CW    = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask_i,
  input  logic            pop_i,
  output logic [CW-1:0]   count_o,
  output logic            illegal_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NREG; i++) count_o = count_o + CW'(mask_i[i]);
  end

  logic empty_w, has_sp_w, push_pc_w, pop_lr_pc_w;
  assign empty_w     = (mask_i == '0);
  assign has_sp_w    = mask_i[SP_IDX];
  assign push_pc_w   = !pop_i && mask_i[PC_IDX];
  assign pop_lr_pc_w = pop_i && mask_i[PC_IDX] && mask_i[LR_IDX];
  assign illegal_o   = empty_w | has_sp_w | push_pc_w | pop_lr_pc_w;
endmodule

// File: rtl/stk_bit_pick.sv
module stk_bit_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  input  logic            hi_first_i,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      // ascending scan: last hit wins for high-first, first hit for low-first
      if (mask_i[i] && (hi_first_i || !any_o)) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq #(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int IW    = $clog2(NREG),
  localparam int CW    = $clog2(NREG + 1),
  localparam int WORD_B = DW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            pop_i,
  input  logic [NREG-1:0] reg_mask_i,
  input  logic [AW-1:0]   sp_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            fault_o,
  output logic            br_valid_o,
  output logic [DW-1:0]   br_target_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            sp_we_o,
  output logic [AW-1:0]   sp_wdata_o
);
  import stk_pkg::*;

  stk_state_e      state_q;
  logic [NREG-1:0] mask_q;
  logic            pop_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   sp_fin_q;
  logic            err_q;
  logic            pc_hit_q;
  logic [DW-1:0]   pc_val_q;

  logic [CW-1:0]   cnt_w;
  logic            illegal_w;
  logic [IW-1:0]   idx_w;
  logic            any_w;
  logic [AW-1:0]   span_w;
  logic [NREG-1:0] mask_nxt_w;
  logic            beat_w;
  logic            idx_pc_w;

  stk_list_check #(
    .NREG(NREG), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX), .PC_IDX(PC_IDX)
  ) u_chk_list (
    .mask_i    (reg_mask_i),
    .pop_i     (pop_i),
    .count_o   (cnt_w),
    .illegal_o (illegal_w)
  );

  stk_bit_pick #(.NREG(NREG)) u_pick (
    .mask_i     (mask_q),
    .hi_first_i (!pop_q),
    .idx_o      (idx_w),
    .any_o      (any_w)
  );

  assign span_w     = AW'(cnt_w) * AW'(WORD_B);
  assign mask_nxt_w = mask_q & ~(NREG'(1) << idx_w);
  assign beat_w     = (state_q == ST_XFER) && mem_ready_i;
  assign idx_pc_w   = (idx_w == IW'(PC_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      pop_q    <= 1'b0;
      addr_q   <= '0;
      sp_fin_q <= '0;
      err_q    <= 1'b0;
      pc_hit_q <= 1'b0;
      pc_val_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pop_q    <= pop_i;
            pc_hit_q <= 1'b0;
            if (illegal_w) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              err_q    <= 1'b0;
              mask_q   <= reg_mask_i;
              addr_q   <= pop_i ? sp_i : sp_i - AW'(WORD_B);
              sp_fin_q <= pop_i ? sp_i + span_w : sp_i - span_w;
              state_q  <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (mem_ready_i) begin
            mask_q <= mask_nxt_w;
            addr_q <= pop_q ? addr_q + AW'(WORD_B) : addr_q - AW'(WORD_B);
            if (pop_q && idx_pc_w) begin
              pc_hit_q <= 1'b1;
              pc_val_q <= mem_rdata_i;
            end
            if (mask_nxt_w == '0) state_q <= ST_WB;
          end
        end
        ST_WB:   state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = done_o && err_q;
  assign br_valid_o  = done_o && pc_hit_q && pc_val_q[0];
  assign fault_o     = done_o && pc_hit_q && !pc_val_q[0];
  assign br_target_o = {pc_val_q[DW-1:1], 1'b0};

  assign mem_req_o   = (state_q == ST_XFER) && any_w;
  assign mem_we_o    = !pop_q;
  assign mem_addr_o  = addr_q;
  assign rf_raddr_o  = idx_w;
  assign mem_wdata_o = rf_rdata_i;

  assign rf_we_o    = beat_w && pop_q && !idx_pc_w;
  assign rf_waddr_o = idx_w;
  assign rf_wdata_o = mem_rdata_i;

  assign sp_we_o    = (state_q == ST_WB);
  assign sp_wdata_o = sp_fin_q;
endmodule

// File: rtl/stk_xfer_seq_chk.sv
module stk_xfer_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            pop_i,
  input logic [NREG-1:0] reg_mask_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic            fault_o,
  input logic            br_valid_o,
  input logic [DW-1:0]   br_target_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_wdata_o,
  input logic            mem_ready_i,
  input logic            rf_we_o,
  input logic [IW-1:0]   rf_waddr_o,
  input logic            sp_we_o
);
  // R10
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && (!mem_we_o || $stable(mem_wdata_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> done_o && !err_o);

  // R3
  sp_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> !sp_we_o);

  // R4
  empty_noacc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (reg_mask_i == '0) |=> done_o && err_o && !mem_req_o);

  // R6
  push_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !pop_i && reg_mask_i[15] |=> err_o && !mem_req_o);

  // R4
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !sp_we_o && !mem_req_o && !fault_o && !br_valid_o);

  // R8
  br_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_o |-> !br_target_o[0] && !fault_o);

  // R8
  no_pc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != IW'(15)) && !mem_we_o);
endmodule

bind stk_xfer_seq stk_xfer_seq_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/stk_xfer_seq_tb.sv
module stk_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [15:0] reg_mask_i = '0;
  logic [31:0] sp_i = '0;
  logic        busy_o, done_o, err_o, fault_o, br_valid_o;
  logic [31:0] br_target_o;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, sp_we_o;
  logic [31:0] sp_wdata_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stk_xfer_seq u_dut (.*);

  logic [31:0] mem [64];
  logic [31:0] rf [16];
  int wait_cfg = 0;
  int wcnt = 0;
  assign mem_ready_i = mem_req_o && (wcnt >= wait_cfg);
  assign mem_rdata_i = mem[mem_addr_o[7:2]];
  assign rf_rdata_i  = rf[rf_raddr_o];

  logic        mon_clr = 1'b0;
  int          acc_cnt, sp_cnt, done_cnt, done_hi;
  logic        err_seen, fault_seen, br_seen, ord_bad, have_prev;
  logic [31:0] br_tgt, sp_val, prev_addr;

  always @(posedge clk_i) begin
    if (mem_req_o && !mem_ready_i) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req_o && mem_ready_i && mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    if (mon_clr) begin
      acc_cnt <= 0; sp_cnt <= 0; done_cnt <= 0; done_hi <= 0;
      err_seen <= 0; fault_seen <= 0; br_seen <= 0; ord_bad <= 0; have_prev <= 0;
    end else begin
      if (mem_req_o && mem_ready_i) begin
        acc_cnt <= acc_cnt + 1;
        if (have_prev && mem_addr_o != (pop_i ? prev_addr + 32'd4 : prev_addr - 32'd4))
          ord_bad <= 1'b1;
        prev_addr <= mem_addr_o;
        have_prev <= 1'b1;
      end
      if (sp_we_o) begin sp_cnt <= sp_cnt + 1; sp_val <= sp_wdata_o; end
      if (done_o) begin
        done_cnt <= done_cnt + 1;
        err_seen <= err_o; fault_seen <= fault_o; br_seen <= br_valid_o; br_tgt <= br_target_o;
      end
      if (done_o) done_hi <= done_hi + 1;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input bit pop, input logic [15:0] mask, input logic [31:0] sp,
                         input bit extra_start);
    @(negedge clk_i);
    pop_i = pop; reg_mask_i = mask; sp_i = sp; start_i = 1'b1; mon_clr = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; mon_clr = 1'b0;
    if (extra_start) begin
      @(negedge clk_i);
      reg_mask_i = 16'h00F0; sp_i = sp - 32'h20; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0; reg_mask_i = mask; sp_i = sp;
    end
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk_i);
    if (done_cnt == 0) chk(1'b0, "R11 done timeout", 0, 1);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic fill_rf();
    for (int i = 0; i < 16; i++) rf[i] = 32'hA500_0000 + 32'(i) * 32'h0101;
  endtask

  task automatic t_push(input logic [15:0] mask, input logic [31:0] sp, input int waits, input bit extra);
    int n, k;
    bit ok;
    fill_rf();
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    wait_cfg = waits;
    run_cmd(1'b0, mask, sp, extra);
    n = $countones(mask);
    ok = 1; k = 0;
    for (int i = 0; i < 16; i++) if (mask[i]) begin
      if (mem[(sp - 32'(4*n) + 32'(4*k)) >> 2 & 32'h3F] != rf[i]) ok = 0;
      k++;
    end
    chk(ok, "R1 push placement", 32'(mask), 32'(sp));
    chk(!ord_bad && acc_cnt == n, "R1 push order/count", 32'(acc_cnt), 32'(n));
    chk(sp_cnt == 1 && sp_val == sp - 32'(4*n), "R3 push sp writeback", sp_val, sp - 32'(4*n));
    chk(!err_seen && done_hi == 1, "R11 push done pulse", 32'(done_hi), 1);
  endtask

  task automatic t_pop(input logic [15:0] mask, input logic [31:0] sp, input int waits,
                       input logic [31:0] pc_word);
    int n, k;
    bit ok;
    logic [31:0] exp_w;
    for (int i = 0; i < 16; i++) rf[i] = 32'h1111_0000 + 32'(i);
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + 32'(i) * 32'h10;
    n = $countones(mask);
    if (mask[15]) mem[((sp >> 2) + 32'(n - 1)) & 32'h3F] = pc_word;
    wait_cfg = waits;
    run_cmd(1'b1, mask, sp, 1'b0);
    ok = 1; k = 0;
    for (int i = 0; i < 16; i++) begin
      exp_w = mask[i] ? mem[((sp >> 2) + 32'(k)) & 32'h3F] : 32'h1111_0000 + 32'(i);
      if (i == 15) exp_w = 32'h1111_000F;
      if (rf[i] != exp_w) ok = 0;
      if (mask[i]) k++;
    end
    chk(ok, "R2 pop placement (R8 no PC write)", 32'(mask), 32'(sp));
    chk(!ord_bad && acc_cnt == n, "R2 pop order/count", 32'(acc_cnt), 32'(n));
    chk(sp_cnt == 1 && sp_val == sp + 32'(4*n), "R3 pop sp writeback", sp_val, sp + 32'(4*n));
    if (mask[15]) begin
      if (pc_word[0]) begin
        chk(br_seen && !fault_seen && br_tgt == {pc_word[31:1], 1'b0}, "R8 branch target",
            br_tgt, {pc_word[31:1], 1'b0});
      end else begin
        chk(fault_seen && !br_seen, "R9 even PC fault", {30'd0, fault_seen, br_seen}, 32'h2);
      end
    end else begin
      chk(!br_seen && !fault_seen, "R8 no branch without PC", {30'd0, fault_seen, br_seen}, 0);
    end
  endtask

  task automatic t_illegal(input bit pop, input logic [15:0] mask, input string tag);
    run_cmd(pop, mask, 32'h80, 1'b0);
    chk(err_seen && acc_cnt == 0 && sp_cnt == 0 && done_hi == 1, tag,
        {16'(acc_cnt), 8'(sp_cnt), 7'd0, err_seen}, 32'h1);
  endtask

  initial begin
    acc_cnt = 0; sp_cnt = 0; done_cnt = 0; done_hi = 0;
    err_seen = 0; fault_seen = 0; br_seen = 0; ord_bad = 0; have_prev = 0;
    br_tgt = '0; sp_val = '0; prev_addr = '0;
    fill_rf();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !sp_we_o && !rf_we_o, "R11 reset idle",
        {27'd0, busy_o, done_o, mem_req_o, sp_we_o, rf_we_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    t_push(16'h0001, 32'h80, 0, 1'b0);
    t_push(16'h5A05, 32'hC0, 0, 1'b0);
    t_push(16'h5FFF, 32'hF0, 2, 1'b0);   // R10 wait states
    t_push(16'h0842, 32'h80, 1, 1'b1);   // R11 start while busy ignored
    t_pop(16'h0081, 32'h40, 0, 32'h0);
    t_pop(16'h4FFF, 32'h20, 3, 32'h0);   // R7 LR alone legal, R10 waits
    t_pop(16'h8006, 32'h60, 1, 32'h0000_1235);  // R8 odd PC
    t_pop(16'h8000, 32'h10, 0, 32'h0000_2468);  // R9 even PC
    t_illegal(1'b0, 16'h0000, "R4 empty push");
    t_illegal(1'b1, 16'h0000, "R4 empty pop");
    t_illegal(1'b0, 16'h2003, "R5 SP in push");
    t_illegal(1'b1, 16'h2010, "R5 SP in pop");
    t_illegal(1'b0, 16'h8001, "R6 PC in push");
    t_illegal(1'b1, 16'hC001, "R7 LR+PC in pop");
    t_push(16'h0003, 32'h80, 0, 1'b0);    // recovers after errors

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule